// File: doc/BRIEF.md
# Serial configuration bit streamer

This block is the read side of a serial configuration store that feeds a slave device one bit at a time. An address counter walks through a small internal bit array. The current bit sits on `dout_o`, and a bit clock `cclk_o` goes out with it. Data changes on the falling edge of the bit clock and is held steady across the rising edge, so the receiver captures on the rising edge. When the last bit has been clocked, the block stops driving its clock and raises a cascade enable, so the next store in a chain can take over.

The bit clock has one of two sources. In external mode, each rising edge of `ext_clk_i` moves the bit clock one half period. In internal mode, a divided system clock plays the role of an oscillator, with a fast ratio and a slow ratio to choose from. A flow-control input can freeze the address while the clock keeps running. An optional decompression mode takes a data-ready input in place of a decompressor: the clock is held low while data is not ready, and the flow-control input is ignored.

Top module: `cfg_bit_streamer`

## Requirements
- R1: A synchronous `rst` or a low `oe_rst_n_i` sets the address to 0, the clock phase to low and `casc_en_o` to 0. `dout_o` then shows the bit at address 0.
- R2: `cclk_drv_o` is 1 only while `ce_n_i` is 0, `oe_rst_n_i` is 1 and the stream is not finished. When `cclk_drv_o` is 0, `cclk_o` is high impedance.
- R3: With the internal source (`src_int_i`=1), the bit clock period is 2*FAST_DIV system cycles when `slow_i`=0 and 2*SLOW_DIV cycles when `slow_i`=1.
- R4: With the external source, each rising edge of `ext_clk_i` toggles the bit clock once, one system clock edge after the edge is seen.
- R5: The bit at address a is the parity of (a AND ROM_MASK). The address advances by one on each falling bit-clock edge, so the bits come out in the order 0 to DEPTH-1, each stable across its rising edge.
- R6: A high `busy_i` at a falling bit-clock edge keeps the address and `dout_o` unchanged, while the bit clock keeps toggling.
- R7: The falling edge after the rising edge of bit DEPTH-1 ends the stream. `casc_en_o` rises, `cclk_drv_o` falls, `dout_o` holds the last bit, and further source edges have no effect.
- R8: In decompression mode (`decomp_i`=1), a low `data_rdy_i` holds `cclk_o` low and blocks clock edges.
- R9: In decompression mode, `busy_i` is ignored and the address advances on every falling edge.
- R10: While `ce_n_i` is 1, the address and the clock phase are frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_rst_n_i | input | 1 | Output enable; low clears the stream |
| busy_i | input | 1 | Flow control; high holds the address |
| ext_clk_i | input | 1 | External bit clock source |
| src_int_i | input | 1 | 1 selects the internal divided source |
| slow_i | input | 1 | 1 selects the slow internal ratio |
| decomp_i | input | 1 | Decompression gating mode |
| data_rdy_i | input | 1 | Data ready from the data path |
| cclk_o | output | 1 | Source-synchronous bit clock |
| cclk_drv_o | output | 1 | 1 while cclk_o is driven |
| dout_o | output | 1 | Serial data bit |
| casc_en_o | output | 1 | Cascade enable for the next device |

## Verification
Each rising edge on `ext_clk_i` is registered once by the edge detector. The bit clock phase and the address therefore update at the first system edge that sees the source high, and `cclk_o`, `dout_o` and `casc_en_o` settle before the next falling system edge. The bench drives a source edge over two system cycles and samples one full cycle later, on a falling system edge, and it advances its own model of phase, address and finish flag once per source edge. The internal-divider periods are measured as the number of cycles between rising edges of `cclk_o` seen at falling system edges.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic run;   // enabled and not finished
        logic rdy;   // data path ready (forced in plain mode)
        logic busy;  // effective hold request
    } seq_ctl_t;

    function automatic logic stored_bit(input int unsigned addr, input int unsigned mask);
        return ^(addr & mask);
    endfunction

endpackage

// File: rtl/cfg_tick_gen.sv
module cfg_tick_gen
    import cfg_stream_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 5
) (
    input  logic     clk,
    input  logic     rst,
    input  clk_src_e src_i,
    input  logic     slow_i,
    input  logic     ext_clk_i,
    output logic     tick_o
);
    localparam int MAXD = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
    localparam int CW   = $clog2(MAXD + 1);

    logic          ext_q;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    assign lim = slow_i ? CW'(SLOW_DIV - 1) : CW'(FAST_DIV - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_q <= 1'b0;
            cnt   <= '0;
        end else begin
            ext_q <= ext_clk_i;
            if (src_i == SRC_INT)
                cnt <= (cnt >= lim) ? '0 : cnt + CW'(1);
            else
                cnt <= '0;
        end
    end

    assign tick_o = (src_i == SRC_INT) ? (cnt >= lim) : (ext_clk_i & ~ext_q);

    // R4
    ext_single_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (src_i == SRC_EXT && tick_o) |=> !tick_o);

endmodule

// File: rtl/cfg_bit_rom.sv
module cfg_bit_rom
    import cfg_stream_pkg::*;
#(
    parameter int          DEPTH    = 32,
    parameter int unsigned ROM_MASK = 32'h2D,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic [AW-1:0] addr_i,
    output logic          bit_o
);
    logic [DEPTH-1:0] bits;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        assign bits[i] = stored_bit(i, ROM_MASK);
    end

    assign bit_o = bits[addr_i];

endmodule

// File: rtl/cfg_addr_seq.sv
module cfg_addr_seq
    import cfg_stream_pkg::*;
#(
    parameter int  DEPTH = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          oe_rst_n_i,
    input  logic          tick_i,
    input  seq_ctl_t      ctl_i,
    output logic [AW-1:0] addr_o,
    output logic          phase_o,
    output logic          done_o
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic clear;
    logic step;
    logic fall;

    assign clear = rst | ~oe_rst_n_i;
    assign step  = tick_i & ctl_i.run & ctl_i.rdy;
    assign fall  = step & phase_o;

    always_ff @(posedge clk) begin
        if (clear) begin
            addr_o  <= '0;
            phase_o <= 1'b0;
            done_o  <= 1'b0;
        end else if (step) begin
            phase_o <= ~phase_o;
            if (phase_o && !ctl_i.busy) begin
                if (addr_o == LAST) done_o <= 1'b1;
                else                addr_o <= addr_o + AW'(1);
            end
        end
    end

    // R5
    addr_step_chk: assert property (@(posedge clk) disable iff (clear)
        (fall && !ctl_i.busy && !done_o) |=> (done_o || addr_o == $past(addr_o) + AW'(1)));
    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (clear)
        (fall && ctl_i.busy) |=> (addr_o == $past(addr_o)));
    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (clear)
        done_o |=> (done_o && $stable(addr_o)));
    // R10
    frozen_chk: assert property (@(posedge clk) disable iff (clear)
        !ctl_i.run |=> ($stable(addr_o) && $stable(phase_o)));

endmodule

// File: rtl/cfg_bit_streamer.sv
module cfg_bit_streamer
    import cfg_stream_pkg::*;
#(
    parameter int          DEPTH    = 32,
    parameter int          FAST_DIV = 2,
    parameter int          SLOW_DIV = 5,
    parameter int unsigned ROM_MASK = 32'h2D
) (
    input  logic clk,
    input  logic rst,
    input  logic ce_n_i,
    input  logic oe_rst_n_i,
    input  logic busy_i,
    input  logic ext_clk_i,
    input  logic src_int_i,
    input  logic slow_i,
    input  logic decomp_i,
    input  logic data_rdy_i,
    output logic cclk_o,
    output logic cclk_drv_o,
    output logic dout_o,
    output logic casc_en_o
);
    localparam int AW = $clog2(DEPTH);

    seq_ctl_t      ctl;
    clk_src_e      src;
    logic          tick;
    logic [AW-1:0] addr;
    logic          phase;
    logic          done;

    assign src      = src_int_i ? SRC_INT : SRC_EXT;
    assign ctl.run  = ~ce_n_i & oe_rst_n_i & ~done;
    assign ctl.rdy  = ~decomp_i | data_rdy_i;
    assign ctl.busy = busy_i & ~decomp_i;

    cfg_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst(rst), .src_i(src), .slow_i(slow_i),
        .ext_clk_i(ext_clk_i), .tick_o(tick)
    );

    cfg_addr_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst(rst), .oe_rst_n_i(oe_rst_n_i), .tick_i(tick),
        .ctl_i(ctl), .addr_o(addr), .phase_o(phase), .done_o(done)
    );

    cfg_bit_rom #(.DEPTH(DEPTH), .ROM_MASK(ROM_MASK)) u_rom (
        .addr_i(addr), .bit_o(dout_o)
    );

    assign cclk_drv_o = ctl.run;
    assign cclk_o     = cclk_drv_o ? (phase & ctl.rdy) : 1'bz;
    assign casc_en_o  = done;

    // R1
    oe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !oe_rst_n_i |=> !casc_en_o);
    // R8
    not_ready_low_chk: assert property (@(posedge clk) disable iff (rst)
        (decomp_i && !data_rdy_i && cclk_drv_o) |-> !cclk_o);
    // R7
    end_release_chk: assert property (@(posedge clk) disable iff (rst)
        casc_en_o |-> !cclk_drv_o);

endmodule

// File: tb/cfg_bit_streamer_test.sv
module cfg_bit_streamer_test;
    localparam int          DEPTH    = 32;
    localparam int          FAST_DIV = 2;
    localparam int          SLOW_DIV = 5;
    localparam int unsigned MASK     = 32'h2D;

    logic clk = 1'b0;
    logic rst, ce_n_i, oe_rst_n_i, busy_i, ext_clk_i, src_int_i, slow_i, decomp_i, data_rdy_i;
    logic cclk_o, cclk_drv_o, dout_o, casc_en_o;

    int checks = 0;
    int fails  = 0;
    int exp_addr = 0;
    logic exp_phase = 1'b0;
    logic exp_done  = 1'b0;

    always #10 clk = ~clk;

    cfg_bit_streamer #(.DEPTH(DEPTH), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .ROM_MASK(MASK)) uut (
        .clk(clk), .rst(rst), .ce_n_i(ce_n_i), .oe_rst_n_i(oe_rst_n_i), .busy_i(busy_i),
        .ext_clk_i(ext_clk_i), .src_int_i(src_int_i), .slow_i(slow_i), .decomp_i(decomp_i),
        .data_rdy_i(data_rdy_i), .cclk_o(cclk_o), .cclk_drv_o(cclk_drv_o), .dout_o(dout_o),
        .casc_en_o(casc_en_o)
    );

    function automatic logic pbit(input int a);
        return logic'($countones(a & MASK) % 2);
    endfunction

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // One external source edge (R4), then the model update and the port checks.
    task automatic step(input logic b, input logic cen, input string req);
        logic rdy_eff;
        logic busy_eff;
        @(negedge clk);
        busy_i = b; ce_n_i = cen; ext_clk_i = 1'b1;
        @(negedge clk);
        ext_clk_i = 1'b0;
        @(negedge clk);
        rdy_eff  = !decomp_i || data_rdy_i;
        busy_eff = b && !decomp_i;
        if (!cen && !exp_done && rdy_eff) begin
            if (exp_phase) begin
                if (!busy_eff) begin
                    if (exp_addr == DEPTH - 1) exp_done = 1'b1;
                    else exp_addr++;
                end
                exp_phase = 1'b0;
            end else begin
                exp_phase = 1'b1;
            end
        end
        chk(cclk_drv_o == (!cen && !exp_done), req, int'(cclk_drv_o), int'(!cen && !exp_done));
        if (!cen && !exp_done)
            chk(cclk_o == (exp_phase && rdy_eff), req, int'(cclk_o), int'(exp_phase && rdy_eff));
        chk(dout_o == pbit(exp_addr), req, int'(dout_o), int'(pbit(exp_addr)));
        chk(casc_en_o == exp_done, req, int'(casc_en_o), int'(exp_done));
        ce_n_i = 1'b0; busy_i = 1'b0;
    endtask

    task automatic oe_clear;
        @(negedge clk) oe_rst_n_i = 1'b0;
        @(negedge clk) oe_rst_n_i = 1'b1;
        exp_addr = 0; exp_phase = 1'b0; exp_done = 1'b0;
    endtask

    task automatic measure(input int exp_period, input string req);
        logic prev;
        int   t0;
        int   t1;
        int   cyc;
        t0 = -1; t1 = -1; cyc = 0;
        prev = cclk_o;
        for (int i = 0; i < 200 && t1 < 0; i++) begin
            @(negedge clk);
            cyc++;
            if (cclk_drv_o && cclk_o && !prev) begin
                if (t0 < 0) t0 = cyc; else t1 = cyc;
            end
            prev = cclk_drv_o ? cclk_o : 1'b0;
        end
        chk((t1 - t0) == exp_period, req, t1 - t0, exp_period);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst = 1'b1; ce_n_i = 1'b1; oe_rst_n_i = 1'b0; busy_i = 1'b0; ext_clk_i = 1'b0;
        src_int_i = 1'b0; slow_i = 1'b0; decomp_i = 1'b0; data_rdy_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R2 released clock
        chk(casc_en_o == 1'b0, "R1", int'(casc_en_o), 0);
        chk(dout_o == pbit(0), "R1", int'(dout_o), int'(pbit(0)));
        chk(cclk_drv_o == 1'b0, "R2", int'(cclk_drv_o), 0);
        oe_rst_n_i = 1'b1; ce_n_i = 1'b0;
        @(negedge clk);
        chk(cclk_drv_o == 1'b1 && cclk_o == 1'b0, "R2", int'(cclk_drv_o), 1);

        // Full stream with busy holds (R6) and chip-enable pauses (R10), R4/R5 otherwise
        for (int k = 0; k < 400 && !exp_done; k++) begin
            logic b;
            logic cen;
            b   = (k % 5 == 3);
            cen = (k % 11 == 7);
            step(b, cen, cen ? "R10" : (b ? "R6" : "R5"));
        end
        chk(exp_done == 1'b1, "R7", int'(exp_done), 1);
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R7");

        // R1: output-enable low clears the finished stream
        oe_clear();
        @(negedge clk);
        chk(casc_en_o == 1'b0, "R1", int'(casc_en_o), 0);
        chk(dout_o == pbit(0) && cclk_drv_o, "R1", int'(dout_o), int'(pbit(0)));

        // R8: not ready holds the clock low
        decomp_i = 1'b1; data_rdy_i = 1'b0;
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, "R8");
        // R9: busy ignored in decompression mode
        data_rdy_i = 1'b1;
        for (int k = 0; k < 8; k++) step(1'b1, 1'b0, "R9");
        chk(exp_addr == 4, "R9", exp_addr, 4);
        decomp_i = 1'b0;

        // R3: internal divided source, both ratios
        oe_clear();
        src_int_i = 1'b1; slow_i = 1'b0;
        measure(2 * FAST_DIV, "R3");
        oe_clear();
        slow_i = 1'b1;
        measure(2 * SLOW_DIV, "R3");

        summary();
    end
endmodule